// File: doc/BRIEF.md
# Delayed Parity Checker with Error Latch

This block checks even parity over a registered command/address word whose parity bit arrives late. At every clock edge it folds the data bits covered by the current configuration into a single parity bit and keeps it in a short delay line. One or two edges later the parity input for that word arrives. At that edge the block combines it with the stored bit. The result is registered on a partial-parity output. Any mismatch pulls an active-low error flag, and the flag then stays low for a fixed number of cycles.

Two configuration inputs choose the coverage set and the lag. One selects a single wide checker. The other two settings select the first or the second checker of a cascaded pair. In a pair, the first checker's partial-parity output drives the second checker's parity input. The second checker's error flag is then the one that counts, and the first one's flag is ignored. Two active-low chip-select inputs freeze both outputs when both are high. A synchronous active-low reset clears everything.

Top module: `dpc_parity_check`

## Requirements
- R1: While `rst_n` is low at a rising edge, after that edge `ppo` is 0 and `err_n` is 1, and the data-parity history is cleared to 0.
- R2: Data bit D(n) is carried on `d_in[n-1]`. The covered set is selected from `cfg_late`/`cfg_pair` as follows:
  - (0,0): D2, D3, D5, D6 and D8..D25.
  - (0,1): D2, D3, D5, D6 and D8..D14.
  - (1,1): D1..D6, D8..D10, D12 and D13.
  Bits outside the selected set never affect `ppo` or `err_n`.
- R3: With `cfg_late`=0 at the comparing edge, `ppo` after edge k+1 equals the XOR of the covered bits captured at edge k with `par_in` at edge k+1.
- R4: With `cfg_late`=1 at the comparing edge, `par_in` at edge k+2 is combined with the covered bits captured at edge k.
- R5: At a comparing edge that is not gated, `err_n` goes low after that edge exactly when the new `ppo` is 1. While `ppo` is 1, `err_n` is low.
- R6: Once `err_n` has gone low, it stays low for 2 clock cycles. It returns high after the second following ungated edge that shows no mismatch.
- R7: A mismatch while the low period is running restarts the 2-cycle count.
- R8: At an edge where `cs_a_n` and `cs_b_n` are both high, `ppo`, `err_n` and the remaining hold count keep their values. The data-parity history still advances.
- R9: The unlisted setting `cfg_late`=1, `cfg_pair`=0 uses the (1,1) coverage set and the two-cycle lag.
- R10: In a cascade, the second checker (`cfg_late`=1, `cfg_pair`=1) takes the first checker's (`cfg_late`=0, `cfg_pair`=1) `ppo` as its `par_in`. The second checker's `err_n` reports the combined parity of both words with the pair's parity bit, two edges after the data.
- R11: A reset during the low period ends it: `err_n` is 1 after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| d_in | input | DATA_W | Registered data word; D(n) on bit n-1 |
| par_in | input | 1 | Late parity bit for an earlier word |
| cs_a_n | input | 1 | Chip select A, active low |
| cs_b_n | input | 1 | Chip select B, active low; both high freezes outputs |
| cfg_late | input | 1 | Lag select: 0 gives one cycle, 1 gives two cycles with the pair-B coverage |
| cfg_pair | input | 1 | Coverage select when `cfg_late` is 0: 0 wide, 1 pair-A |
| ppo | output | 1 | Partial-parity result, feeds a cascaded checker |
| err_n | output | 1 | Active-low, stretched error flag |

## Verification
Data parity is due at the comparison edge: one edge after capture with `cfg_late`=0 and two edges after with `cfg_late`=1. `ppo` and `err_n` change at that edge, and the release of `err_n` comes two ungated clean edges later. The bench drives all inputs just after a falling edge and steps a reference model at the rising edge. It compares both outputs at the next falling edge, so each result is read in the cycle it first becomes visible. The cascade trials read the second checker's flag after the edge two cycles past the data, then idle long enough for any hold to expire.

// File: rtl/dpc_pkg.sv
// Package: shared types for the delayed parity checker.
// Assumes: three coverage sets, chosen by two configuration bits.
package dpc_pkg;

    // Which coverage set applies to the captured word.
    typedef enum logic [1:0] {
        SEL_FULL   = 2'd0,
        SEL_PAIR_A = 2'd1,
        SEL_PAIR_B = 2'd2
    } sel_mode_t;

    // Late-lag setting always means pair-B coverage; otherwise the pair bit picks.
    function automatic sel_mode_t decode_sel(input logic late, input logic pair);
        if (late)
            return SEL_PAIR_B;
        else if (pair)
            return SEL_PAIR_A;
        else
            return SEL_FULL;
    endfunction

endpackage

// File: rtl/dpc_cover_parity.sv
// Module: reduces the covered bits of a data word to one parity bit.
// Assumes: masks are static per mode; all three reductions run in parallel
// and the mode only steers the final mux, keeping select off the XOR trees.
module dpc_cover_parity
    import dpc_pkg::*;
#(
    parameter int                DATA_W    = 25,
    parameter logic [DATA_W-1:0] MASK_FULL = 25'h1FFFFB6,
    parameter logic [DATA_W-1:0] MASK_A    = 25'h0003FB6,
    parameter logic [DATA_W-1:0] MASK_B    = 25'h0001BBF
) (
    input  logic [DATA_W-1:0] d_in,
    input  sel_mode_t         mode,
    output logic              par_out
);

    localparam int NUM_MODES = 3;

    logic [NUM_MODES-1:0] mode_par;

    // One masked XOR reduction per coverage set.
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        localparam logic [DATA_W-1:0] SET_MASK =
            (m == 0) ? MASK_FULL : ((m == 1) ? MASK_A : MASK_B);
        assign mode_par[m] = ^(d_in & SET_MASK);
    end

    // Pick the reduction belonging to the active mode.
    always_comb begin
        case (mode)
            SEL_PAIR_A: par_out = mode_par[1];
            SEL_PAIR_B: par_out = mode_par[2];
            default:    par_out = mode_par[0];
        endcase
    end

endmodule

// File: rtl/dpc_lag_line.sv
// Module: shift line holding the data parity of the last DEPTH edges.
// Assumes: taps[i] holds the parity captured i+1 edges before the current edge.
module dpc_lag_line #(
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    output logic [DEPTH-1:0] taps
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            // Capture the newest data parity.
            always_ff @(posedge clk) begin
                if (!rst_n) taps[0] <= 1'b0;
                else        taps[0] <= bit_in;
            end
        end else begin : g_tail
            // Age the history by one edge.
            always_ff @(posedge clk) begin
                if (!rst_n) taps[i] <= 1'b0;
                else        taps[i] <= taps[i-1];
            end
        end
    end

endmodule

// File: rtl/dpc_result_stage.sv
// Module: registers the compare result and stretches the error flag.
// Assumes: freeze holds every register here, including the hold count;
// a mismatch always reloads the full hold time.
module dpc_result_stage #(
    parameter int HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic freeze,
    input  logic mismatch,
    output logic ppo,
    output logic err_n
);

    localparam int                CNT_W  = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0]  RELOAD = CNT_W'(HOLD_CYC - 1);

    logic [CNT_W-1:0] hold_cnt;

    // Latch the partial-parity result at each ungated compare.
    always_ff @(posedge clk) begin
        if (!rst_n)       ppo <= 1'b0;
        else if (!freeze) ppo <= mismatch;
    end

    // Drive the flag low on a mismatch and keep it low for the hold time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_n    <= 1'b1;
            hold_cnt <= '0;
        end else if (!freeze) begin
            if (mismatch) begin
                err_n    <= 1'b0;
                hold_cnt <= RELOAD;
            end else if (hold_cnt != '0) begin
                hold_cnt <= hold_cnt - 1'b1;
            end else begin
                err_n    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dpc_parity_check.sv
// Module: top of the delayed parity checker.
// Assumes: data is sampled on every rising edge; the parity input for a
// word arrives LAG_EARLY or LAG_LATE edges later, per cfg_late at the
// comparing edge; the coverage set follows the configuration at capture.
module dpc_parity_check
    import dpc_pkg::*;
#(
    parameter int                DATA_W    = 25,
    parameter int                LAG_EARLY = 1,
    parameter int                LAG_LATE  = 2,
    parameter int                HOLD_CYC  = 2,
    parameter logic [DATA_W-1:0] MASK_FULL = 25'h1FFFFB6,
    parameter logic [DATA_W-1:0] MASK_A    = 25'h0003FB6,
    parameter logic [DATA_W-1:0] MASK_B    = 25'h0001BBF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] d_in,
    input  logic              par_in,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic              cfg_late,
    input  logic              cfg_pair,
    output logic              ppo,
    output logic              err_n
);

    localparam int LAG_DEPTH = (LAG_LATE > LAG_EARLY) ? LAG_LATE : LAG_EARLY;

    sel_mode_t            sel_mode;
    logic                 data_par;
    logic [LAG_DEPTH-1:0] par_taps;
    logic                 due_par;
    logic                 freeze;
    logic                 mismatch;

    // Decode the coverage set from the configuration pins.
    assign sel_mode = decode_sel(cfg_late, cfg_pair);

    dpc_cover_parity #(
        .DATA_W    (DATA_W),
        .MASK_FULL (MASK_FULL),
        .MASK_A    (MASK_A),
        .MASK_B    (MASK_B)
    ) u_cover (
        .d_in    (d_in),
        .mode    (sel_mode),
        .par_out (data_par)
    );

    dpc_lag_line #(
        .DEPTH (LAG_DEPTH)
    ) u_lag (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_in (data_par),
        .taps   (par_taps)
    );

    // Pick the stored parity that lines up with the arriving parity bit.
    assign due_par  = cfg_late ? par_taps[LAG_LATE-1] : par_taps[LAG_EARLY-1];
    assign mismatch = par_in ^ due_par;
    assign freeze   = cs_a_n & cs_b_n;

    dpc_result_stage #(
        .HOLD_CYC (HOLD_CYC)
    ) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze   (freeze),
        .mismatch (mismatch),
        .ppo      (ppo),
        .err_n    (err_n)
    );

endmodule

// File: rtl/dpc_parity_check_sva.sv
// Module: property checker for the delayed parity checker, bound to the top.
module dpc_parity_check_sva (
    input logic clk,
    input logic rst_n,
    input logic cs_a_n,
    input logic cs_b_n,
    input logic ppo,
    input logic err_n
);

    AST_RESET_VALUES: assert property (@(posedge clk)
        !rst_n |=> (ppo == 1'b0 && err_n == 1'b1)); // R1

    AST_PPO_FORCES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ppo |-> !err_n); // R5

    AST_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_n) |-> !ppo); // R6

    AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |=> !err_n); // R6

    AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_a_n && cs_b_n) |=> ($stable(ppo) && $stable(err_n))); // R8

endmodule

bind dpc_parity_check dpc_parity_check_sva u_sva (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_a_n (cs_a_n),
    .cs_b_n (cs_b_n),
    .ppo    (ppo),
    .err_n  (err_n)
);

// File: tb/dpc_parity_check_tb_top.sv
// Bench: sweeps coverage, lag, hold, gating, reset and cascade cases
// against an arithmetic reference model.
module dpc_parity_check_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [24:0] d_in = '0;
    logic        par_in = 1'b0;
    logic        cs_a_n = 1'b0;
    logic        cs_b_n = 1'b0;
    logic        cfg_late = 1'b0;
    logic        cfg_pair = 1'b0;
    logic        ppo;
    logic        err_n;

    logic [24:0] c_lo = '0;
    logic [24:0] c_hi = '0;
    logic        c_par = 1'b0;
    logic        ca_ppo, ca_err_n, cb_ppo, cb_err_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference model state.
    bit m_h0 = 0, m_h1 = 0, m_ppo = 0, m_err = 1;
    int m_cnt = 0;

    always #2 clk = ~clk;

    dpc_parity_check dut_i (
        .clk(clk), .rst_n(rst_n), .d_in(d_in), .par_in(par_in),
        .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .cfg_late(cfg_late),
        .cfg_pair(cfg_pair), .ppo(ppo), .err_n(err_n)
    );

    dpc_parity_check casc_a (
        .clk(clk), .rst_n(rst_n), .d_in(c_lo), .par_in(c_par),
        .cs_a_n(1'b0), .cs_b_n(1'b0), .cfg_late(1'b0),
        .cfg_pair(1'b1), .ppo(ca_ppo), .err_n(ca_err_n)
    );

    dpc_parity_check casc_b (
        .clk(clk), .rst_n(rst_n), .d_in(c_hi), .par_in(ca_ppo),
        .cs_a_n(1'b0), .cs_b_n(1'b0), .cfg_late(1'b1),
        .cfg_pair(1'b1), .ppo(cb_ppo), .err_n(cb_err_n)
    );

    // Coverage membership of data bit n (1-based), per R2 and R9.
    function automatic bit covered(bit late, bit pair, int n);
        if (late)
            return (n >= 1 && n <= 6) || (n >= 8 && n <= 10) || n == 12 || n == 13;
        if (n == 2 || n == 3 || n == 5 || n == 6)
            return 1'b1;
        return pair ? (n >= 8 && n <= 14) : (n >= 8 && n <= 25);
    endfunction

    function automatic bit exp_par(logic [24:0] d, bit late, bit pair);
        bit p = 0;
        for (int n = 1; n <= 25; n++)
            if (covered(late, pair, n)) p ^= d[n-1];
        return p;
    endfunction

    task automatic check_bit(string tag, string what, bit got, bit exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s got=%0b exp=%0b t=%0t", tag, what, got, exp, $time);
        end
    endtask

    // One clock: step the model at the rising edge, compare at the falling edge.
    task automatic tick(string tag);
        bit pn, tap, r;
        @(posedge clk);
        if (!rst_n) begin
            m_h0 = 0; m_h1 = 0; m_ppo = 0; m_err = 1; m_cnt = 0;
        end else begin
            pn  = exp_par(d_in, cfg_late, cfg_pair);
            tap = cfg_late ? m_h1 : m_h0;
            m_h1 = m_h0;
            m_h0 = pn;
            if (!(cs_a_n && cs_b_n)) begin
                r = par_in ^ tap;
                m_ppo = r;
                if (r) begin
                    m_err = 0; m_cnt = 1;
                end else if (m_cnt > 0) begin
                    m_cnt--;
                end else begin
                    m_err = 1;
                end
            end
        end
        @(negedge clk);
        check_bit(tag, "ppo", ppo, m_ppo);
        check_bit(tag, "err_n", err_n, m_err);
    endtask

    task automatic drive(logic [24:0] d, bit p, bit a, bit b);
        d_in = d; par_in = p; cs_a_n = a; cs_b_n = b;
    endtask

    task automatic cascade_trial(logic [24:0] lo, logic [24:0] hi, bit p);
        bit exp_err;
        c_lo = lo; c_hi = hi; c_par = 0;
        @(negedge clk);
        c_lo = '0; c_hi = '0; c_par = p;
        @(negedge clk);
        c_par = 0;
        @(negedge clk);
        exp_err = exp_par(lo, 0, 1) ^ exp_par(hi, 1, 1) ^ p;
        check_bit("R10", "cascade err_n", cb_err_n, !exp_err);
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failure that still reaches the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state under arbitrary inputs.
        for (int i = 0; i < 3; i++) begin
            drive(25'($urandom), 1'b1, 1'b0, 1'b0);
            tick("R1");
        end
        rst_n = 1'b1;
        drive('0, 0, 0, 0);
        tick("R1");

        // R2 / R9: walking one through every bit, every configuration.
        for (int c = 0; c < 4; c++) begin
            cfg_late = c[1]; cfg_pair = c[0];
            for (int b = 0; b < 25; b++) begin
                drive(25'(1) << b, 0, 0, 0);
                tick(c == 2 ? "R9" : "R2");
                drive('0, 0, 0, 0);
                tick(c == 2 ? "R9" : "R2");
                tick(c == 2 ? "R9" : "R2");
                tick(c == 2 ? "R9" : "R2");
            end
        end

        // R3: one-cycle lag with random words and parity.
        cfg_late = 0;
        for (int i = 0; i < 300; i++) begin
            cfg_pair = 1'($urandom);
            drive(25'($urandom), 1'($urandom), 0, 0);
            tick("R3");
        end

        // R4: two-cycle lag with random words and parity.
        cfg_late = 1;
        for (int i = 0; i < 300; i++) begin
            cfg_pair = 1'($urandom);
            drive(25'($urandom), 1'($urandom), 0, 0);
            tick("R4");
        end

        // R5 / R6: single mismatch then clean cycles.
        cfg_late = 0; cfg_pair = 0;
        drive('0, 0, 0, 0);
        repeat (4) tick("R6");
        drive('0, 1, 0, 0); tick("R5");
        drive('0, 0, 0, 0);
        repeat (4) tick("R6");

        // R7: back-to-back mismatches restart the hold.
        drive('0, 1, 0, 0); tick("R7");
        tick("R7");
        drive('0, 0, 0, 0);
        repeat (4) tick("R7");

        // R8: chip-select gating, directed then random.
        drive('0, 1, 1, 0); tick("R8");
        drive('0, 0, 1, 1); tick("R8");
        drive('0, 0, 1, 1); tick("R8");
        drive('0, 0, 0, 1); tick("R8");
        tick("R8");
        tick("R8");
        for (int i = 0; i < 300; i++) begin
            cfg_late = 1'($urandom); cfg_pair = 1'($urandom);
            drive(25'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            tick("R8");
        end

        // R11: reset in the middle of a hold period.
        cfg_late = 0; cfg_pair = 0;
        drive('0, 0, 0, 0);
        repeat (3) tick("R11");
        drive('0, 1, 0, 0); tick("R11");
        drive('0, 0, 0, 0);
        rst_n = 1'b0; tick("R11");
        rst_n = 1'b1; tick("R11");
        tick("R11");

        // R10: cascaded pair, matching and mismatching parity.
        repeat (4) @(negedge clk);
        cascade_trial(25'h0000006, 25'h0000001, 1'b1);
        cascade_trial(25'h0000006, 25'h0000001, 1'b0);
        for (int i = 0; i < 20; i++)
            cascade_trial(25'($urandom), 25'($urandom), 1'($urandom));

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule